// File: doc/BRIEF.md
# Quad Lane Shuffle Unit

This unit moves 32-bit values between the lanes of a SIMD vector, where every group of four neighbouring lanes forms a quad and values never leave their quad. It serves quad subgroup operations and derivative-style neighbour exchanges. A 2-bit variant code selects one of four behaviours on a shared datapath: an indexed broadcast of one quad member to the whole quad, or one of three fixed swaps (horizontal, vertical, diagonal). Within a quad, position 0 is top-left, 1 top-right, 2 bottom-left and 3 bottom-right.

The unit is a pure permutation followed by one output register. An operation is presented with a valid strobe, an active-lane mask, the operand vector and a per-lane 2-bit selector. Only the broadcast variant reads the selector. Lanes that are inactive are not written and keep whatever the output register held. A lane whose source lane is inactive receives a value that is not defined, and consumers must not rely on it.

Top module: `quad_lane_shuffle`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, out_valid is 0, out_data is all zeros and out_wmask is 0.
- R2: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low (one-cycle latency).
- R3: Variant 2'b01 (horizontal swap): each active lane at quad position p receives the operand of the lane at position p XOR 1 in its quad.
- R4: Variant 2'b10 (vertical swap): each active lane at position p receives the operand of position p XOR 2.
- R5: Variant 2'b11 (diagonal swap): each active lane at position p receives the operand of position p XOR 3.
- R6: Variant 2'b00 (broadcast): every active lane of a quad receives the operand of the quad position named by the 2-bit selector of the lowest-numbered active lane in that quad.
- R7: In broadcast, selectors of active lanes other than the lowest-numbered active lane, and selectors of inactive lanes, have no effect on the result.
- R8: On an accepted operation, lanes whose active bit is 0 keep their previous out_data value, and out_wmask takes the value of the active mask.
- R9: In a cycle with in_valid low, out_data and out_wmask do not change.
- R10: Each quad is processed independently: lane 4q+p only ever receives a value from lanes 4q..4q+3, and each quad uses its own lowest active lane's selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| variant | input | 2 | 00 broadcast, 01 horizontal, 10 vertical, 11 diagonal |
| operand | input | LANES*DATA_W | Operand vector, lane i at bits [i*DATA_W +: DATA_W] |
| lane_sel | input | LANES*2 | Per-lane broadcast selector, lane i at bits [2*i +: 2] |
| active | input | LANES | Active-lane mask, bit i for lane i |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | LANES*DATA_W | Registered result vector |
| out_wmask | output | LANES | Active mask of the last accepted operation |

## Verification
The permutation for active lanes and the retention of inactive lanes happen in the same cycle on the same register, so a wrong lane enable shows up either as a lost hold or as a missing write. The sweep drives every variant with partial masks that differ per quad, so that each operation writes some lanes while holding others and makes some sources inactive. Written lanes are compared with the arithmetic permutation of the operand, held lanes with the value the bench last expected for them, and lanes whose source was inactive are left out of the comparison until a later operation defines them again.

// File: rtl/qls_pkg.sv
package qls_pkg;

    localparam int QUAD_N = 4;

    typedef enum logic [1:0] {
        QV_BCAST = 2'b00,
        QV_HSWAP = 2'b01,
        QV_VSWAP = 2'b10,
        QV_DSWAP = 2'b11
    } qls_variant_e;

    // Quad position that a lane at position pos reads from.
    function automatic logic [1:0] qls_src_pos(
        input qls_variant_e v,
        input logic [1:0]   pos,
        input logic [1:0]   bsel
    );
        logic [1:0] r;
        if (v == QV_BCAST) begin
            r = bsel;
        end else begin
            r = pos ^ 2'(v);
        end
        return r;
    endfunction

endpackage

// File: rtl/qls_leader.sv
module qls_leader (
    input  logic [3:0] active,
    input  logic [7:0] sel,
    output logic [1:0] bsel
);
    // Lowest-numbered active lane provides the broadcast selector.
    always_comb begin
        bsel = 2'b00;
        for (int p = 3; p >= 0; p--) begin
            if (active[p]) begin
                bsel = sel[p*2 +: 2];
            end
        end
    end
endmodule

// File: rtl/qls_quad_xbar.sv
module qls_quad_xbar
    import qls_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  qls_variant_e           variant,
    input  logic [1:0]             bsel,
    input  logic [4*DATA_W-1:0]    data,
    output logic [4*DATA_W-1:0]    res
);
    always_comb begin
        logic [1:0] src;
        res = '0;
        for (int p = 0; p < QUAD_N; p++) begin
            src = qls_src_pos(variant, 2'(p), bsel);
            res[p*DATA_W +: DATA_W] = data[int'(src)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/quad_lane_shuffle.sv
module quad_lane_shuffle
    import qls_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              variant,
    input  logic [LANES*DATA_W-1:0] operand,
    input  logic [LANES*2-1:0]      lane_sel,
    input  logic [LANES-1:0]        active,
    output logic                    out_valid,
    output logic [LANES*DATA_W-1:0] out_data,
    output logic [LANES-1:0]        out_wmask
);
    localparam int QUADS = LANES / QUAD_N;

    typedef struct packed {
        logic                    vld;
        logic [LANES-1:0]        wmask;
        logic [LANES*DATA_W-1:0] data;
    } qls_state_t;

    qls_state_t               st_d, st_q;
    qls_variant_e             var_e;
    logic [LANES*DATA_W-1:0]  routed;

    assign var_e = qls_variant_e'(variant);

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
        logic [1:0] bsel_q;

        qls_leader u_leader (
            .active (active[q*QUAD_N +: QUAD_N]),
            .sel    (lane_sel[q*QUAD_N*2 +: QUAD_N*2]),
            .bsel   (bsel_q)
        );

        qls_quad_xbar #(.DATA_W(DATA_W)) u_xbar (
            .variant (var_e),
            .bsel    (bsel_q),
            .data    (operand[q*QUAD_N*DATA_W +: QUAD_N*DATA_W]),
            .res     (routed[q*QUAD_N*DATA_W +: QUAD_N*DATA_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.wmask = active;
            for (int i = 0; i < LANES; i++) begin
                if (active[i]) begin
                    st_d.data[i*DATA_W +: DATA_W] = routed[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_wmask = st_q.wmask;

endmodule

// File: rtl/quad_lane_shuffle_chk.sv
module quad_lane_shuffle_chk #(
    parameter int LANES  = 16,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [1:0]              variant,
    input logic [LANES*DATA_W-1:0] operand,
    input logic [LANES-1:0]        active,
    input logic                    out_valid,
    input logic [LANES*DATA_W-1:0] out_data,
    input logic [LANES-1:0]        out_wmask
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_wmask: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_wmask == $past(active));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_data) && $stable(out_wmask)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int P    = i % 4;
        localparam int BASE = i - P;
        localparam int PH   = BASE + (P ^ 1);
        localparam int PV   = BASE + (P ^ 2);
        localparam int PD   = BASE + (P ^ 3);

        a_r8_lane_hold: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !active[i]) |=> $stable(out_data[i*DATA_W +: DATA_W]));

        a_r3_hswap: assert property (@(posedge clk) disable iff (rst)
            (in_valid && variant == 2'b01 && active[i] && active[PH])
            |=> out_data[i*DATA_W +: DATA_W] == $past(operand[PH*DATA_W +: DATA_W]));

        a_r4_vswap: assert property (@(posedge clk) disable iff (rst)
            (in_valid && variant == 2'b10 && active[i] && active[PV])
            |=> out_data[i*DATA_W +: DATA_W] == $past(operand[PV*DATA_W +: DATA_W]));

        a_r5_dswap: assert property (@(posedge clk) disable iff (rst)
            (in_valid && variant == 2'b11 && active[i] && active[PD])
            |=> out_data[i*DATA_W +: DATA_W] == $past(operand[PD*DATA_W +: DATA_W]));
    end
endmodule

bind quad_lane_shuffle quad_lane_shuffle_chk #(
    .LANES  (LANES),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .variant   (variant),
    .operand   (operand),
    .active    (active),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_wmask (out_wmask)
);

// File: tb/quad_lane_shuffle_tb.sv
module quad_lane_shuffle_tb;
    localparam int LANES = 16;
    localparam int DW    = 32;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  in_valid;
    logic [1:0]            variant;
    logic [LANES*DW-1:0]   operand;
    logic [LANES*2-1:0]    lane_sel;
    logic [LANES-1:0]      active;
    logic                  out_valid;
    logic [LANES*DW-1:0]   out_data;
    logic [LANES-1:0]      out_wmask;

    always #5 clk = ~clk;

    quad_lane_shuffle #(.LANES(LANES), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .variant   (variant),
        .operand   (operand),
        .lane_sel  (lane_sel),
        .active    (active),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_wmask (out_wmask)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [DW-1:0]    exp_d   [LANES];
    bit               exp_def [LANES];
    logic [LANES-1:0] exp_wm;
    bit               exp_vld;

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] mkval(int t, int i);
        return DW'(t * 40503 + i * 977) ^ DW'(32'h5A00_0000 | (i << 24));
    endfunction

    // Reference model: updates expected state from the current inputs.
    task automatic model_accept();
        for (int q = 0; q < LANES / 4; q++) begin
            int lead = -1;
            logic [1:0] bs;
            for (int p = 0; p < 4; p++)
                if (active[4*q+p] && lead < 0) lead = p;
            bs = (lead >= 0) ? lane_sel[(4*q+lead)*2 +: 2] : 2'b00;
            for (int p = 0; p < 4; p++) begin
                int s;
                int src;
                if (active[4*q+p]) begin
                    s   = (variant == 2'b00) ? int'(bs) : (p ^ int'(variant));
                    src = 4*q + s;
                    exp_def[4*q+p] = active[src];
                    exp_d[4*q+p]   = operand[src*DW +: DW];
                end
            end
        end
        exp_wm  = active;
        exp_vld = 1'b1;
    endtask

    task automatic check_out(input string vtag);
        chk(out_valid == exp_vld, "R2 out_valid", DW'(out_valid), DW'(exp_vld));
        chk(out_wmask == exp_wm, "R8 out_wmask", DW'(out_wmask), DW'(exp_wm));
        for (int i = 0; i < LANES; i++) begin
            if (exp_def[i])
                chk(out_data[i*DW +: DW] == exp_d[i],
                    exp_wm[i] ? vtag : "R8 held lane",
                    out_data[i*DW +: DW], exp_d[i]);
        end
    endtask

    task automatic do_op(input int t, input logic [1:0] v, input logic [LANES-1:0] m,
                         input int sp);
        in_valid = 1'b1;
        variant  = v;
        active   = m;
        for (int i = 0; i < LANES; i++) begin
            operand[i*DW +: DW] = mkval(t, i);
            lane_sel[i*2 +: 2]  = 2'((sp + 3*i + t) % 4);
        end
        model_accept();
        @(negedge clk);
        case (v)
            2'b00:   check_out("R6 R7 R10 broadcast");
            2'b01:   check_out("R3 R10 horizontal");
            2'b10:   check_out("R4 R10 vertical");
            default: check_out("R5 R10 diagonal");
        endcase
    endtask

    task automatic do_idle(input int t);
        in_valid = 1'b0;
        variant  = 2'(t);
        active   = ~active;
        for (int i = 0; i < LANES; i++) begin
            operand[i*DW +: DW] = ~mkval(t, i);
            lane_sel[i*2 +: 2]  = 2'(i + t);
        end
        exp_vld = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 R2 idle valid", DW'(out_valid), 0);
        chk(out_wmask == exp_wm, "R9 idle wmask", DW'(out_wmask), DW'(exp_wm));
        for (int i = 0; i < LANES; i++)
            if (exp_def[i])
                chk(out_data[i*DW +: DW] == exp_d[i], "R9 idle data",
                    out_data[i*DW +: DW], exp_d[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t;
        rst      = 1'b1;
        in_valid = 1'b0;
        variant  = 2'b00;
        operand  = '0;
        lane_sel = '0;
        active   = '0;
        for (int i = 0; i < LANES; i++) begin
            exp_d[i]   = '0;
            exp_def[i] = 1'b1;
        end
        exp_wm  = '0;
        exp_vld = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state, driving a request during reset has no effect
        in_valid = 1'b1;
        active   = '1;
        operand  = '1;
        @(negedge clk);
        check_out("R1 reset data");
        in_valid = 1'b0;
        rst      = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", DW'(out_valid), 0);
        check_out("R1 data after reset");

        // Exhaustive sweep: every variant, 16 mask seeds rotated per quad, 4 selector seeds
        t = 0;
        for (int v = 0; v < 4; v++) begin
            for (int m = 0; m < 16; m++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    logic [LANES-1:0] msk;
                    for (int q = 0; q < LANES / 4; q++)
                        msk[4*q +: 4] = 4'((m + q * 5 + sp) % 16);
                    do_op(t, 2'(v), msk, sp);
                    t++;
                    if (t % 16 == 7) begin
                        do_idle(t);
                        t++;
                    end
                end
            end
        end

        // Full masks per variant, back to back
        for (int v = 0; v < 4; v++) begin
            do_op(t, 2'(v), '1, v);
            t++;
        end

        // R7: broadcast with only the leader's selector fixed, others swept
        for (int k = 0; k < 4; k++) begin
            in_valid = 1'b1;
            variant  = 2'b00;
            active   = 16'b0110_1100_1110_1011;
            for (int i = 0; i < LANES; i++) begin
                operand[i*DW +: DW] = mkval(t + 1000, i);
                lane_sel[i*2 +: 2]  = 2'(k + i);
            end
            lane_sel[0*2 +: 2]  = 2'd3;
            lane_sel[5*2 +: 2]  = 2'd3;
            lane_sel[10*2 +: 2] = 2'd2;
            lane_sel[13*2 +: 2] = 2'd1;
            model_accept();
            @(negedge clk);
            check_out("R7 R6 leader selector");
            t++;
        end
        do_idle(t);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1;
        $finish;
    end
endmodule